// File: doc/BRIEF.md
# GPIO Ports with Per-Pin Peripheral Override and Edge Interrupt Latches

This block provides two 8-bit bidirectional general-purpose ports, A and B, for a small processor. The processor reaches them over an 8-bit IO bus. Address bits [7:6] select one of four macros, and this block answers only to macro 0. Address bits [5:0] pick a register inside the block. Each port has a direction register, an output register, a synchronized input view and a per-pin override mask.

When a pin's override bit is set, the pin stops following its direction and output bits. An on-chip peripheral then drives the pin's output enable and data through plain peripheral-side ports. Every synchronized pin value is passed back to the peripherals, whatever the override setting.

Three pins also serve as external interrupt requests: A0, B0 and A7. Each one has a rising-edge latch that arms only while that pin's override bit is set. The pending latches go to the CPU as a 3-bit vector. Software reads them through one register and clears them by writing ones to that register.

Top module: `gpio_altmux`

## Requirements
- R1: After reset every register is 0. All pads are inputs (`pad_*_oe_o` = 0), every mapped register reads 0x00 and no interrupt is pending.
- R2: The block responds only when address bits [7:6] are 00. A write to any other macro changes nothing. A read of another macro, or of an offset other than 0x00–0x08, returns 0x00.
- R3: Offsets 0x00 and 0x01 hold the direction of ports A and B, where 1 means drive. Offsets 0x02 and 0x03 hold their output data. All four read back what was written. For a pin whose override bit is 0, `pad_*_oe_o` equals its direction bit and `pad_*_o` equals its output bit.
- R4: Offsets 0x04 (port A) and 0x08 (port B) hold the override masks. For a pin whose mask bit is 1, `pad_*_o` and `pad_*_oe_o` follow `per_*_dout_i` and `per_*_doe_i`, whatever its direction and output bits hold.
- R5: Offsets 0x05 (port A) and 0x06 (port B) read the pad inputs through a two-flop synchronizer. A pad change is readable after the second rising clock edge. Writes to these offsets have no effect.
- R6: `per_*_din_o` carries the synchronized pad values of every pin, whatever the override masks hold.
- R7: Interrupt bit 0 is pin A0, bit 1 is pin B0 and bit 2 is pin A7. A pending bit sets on a low-to-high transition of the synchronized pin while the pin's override bit is 1. It is visible on `irq_pend_o` after the third rising edge following the pad change.
- R8: A rising pin whose override bit is 0 does not set its pending bit. A pin held high does not set it again.
- R9: Clearing a pin's override bit leaves its pending bit unchanged.
- R10: Offset 0x07 reads the pending vector in bits [2:0], with bits [7:3] reading 0. Writing it clears each pending bit whose data bit is 1 and leaves the others unchanged.
- R11: If a new edge sets a pending bit in the same cycle that a write clears it, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | IO address: [7:6] macro, [5:0] offset |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| pad_a_i | input | 8 | Port A pad inputs |
| pad_a_o | output | 8 | Port A pad output data |
| pad_a_oe_o | output | 8 | Port A pad output enables |
| pad_b_i | input | 8 | Port B pad inputs |
| pad_b_o | output | 8 | Port B pad output data |
| pad_b_oe_o | output | 8 | Port B pad output enables |
| per_a_dout_i | input | 8 | Peripheral data for overridden port A pins |
| per_a_doe_i | input | 8 | Peripheral output enables for overridden port A pins |
| per_a_din_o | output | 8 | Synchronized port A pad values to peripherals |
| per_b_dout_i | input | 8 | Peripheral data for overridden port B pins |
| per_b_doe_i | input | 8 | Peripheral output enables for overridden port B pins |
| per_b_din_o | output | 8 | Synchronized port B pad values to peripherals |
| irq_pend_o | output | 3 | Pending external interrupts {A7, B0, A0} |

## Verification
The bench presents a clear write in exactly the cycle a fresh edge is detected. A design that lets the clear win would drop that interrupt. Next, it disables a pin's override while the pin's interrupt is pending, and it also raises a pin whose override is off. A design that gates the stored latch with the enable would lose the pending bit, and a design that never gates the edge would latch a spurious interrupt. It drives a pin high and keeps it high after a clear, which exposes a latch that triggers on level rather than on edge. Finally, it writes to a foreign macro, to an unmapped offset and to the read-only input offsets. A design with a loose address decoder would corrupt a register there or return stale data.

// File: rtl/gpio_altmux_pkg.sv
package gpio_altmux_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int OFF_W  = 6;
  localparam int PORT_W = 8;
  localparam int NIRQ   = 3;
  localparam int SEL_W  = ADDR_W - OFF_W;

  localparam logic [SEL_W-1:0] MACRO_ID = '0;

  localparam logic [OFF_W-1:0] OFF_DIR_A = 6'h00;
  localparam logic [OFF_W-1:0] OFF_DIR_B = 6'h01;
  localparam logic [OFF_W-1:0] OFF_OUT_A = 6'h02;
  localparam logic [OFF_W-1:0] OFF_OUT_B = 6'h03;
  localparam logic [OFF_W-1:0] OFF_OVR_A = 6'h04;
  localparam logic [OFF_W-1:0] OFF_IN_A  = 6'h05;
  localparam logic [OFF_W-1:0] OFF_IN_B  = 6'h06;
  localparam logic [OFF_W-1:0] OFF_IRQ   = 6'h07;
  localparam logic [OFF_W-1:0] OFF_OVR_B = 6'h08;

  // interrupt pin positions: bit0 A0, bit1 B0, bit2 A7
  localparam int IRQ0_BIT = 0;
  localparam int IRQ1_BIT = 0;
  localparam int IRQ2_BIT = PORT_W - 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wdata_i,
  input  logic         we_dir_i,
  input  logic         we_out_i,
  input  logic         we_ovr_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o,
  input  logic [W-1:0] per_dout_i,
  input  logic [W-1:0] per_doe_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] ovr_o
);
  logic [W-1:0] dir_q, out_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
      ovr_q <= '0;
    end else begin
      if (we_dir_i) dir_q <= wdata_i;
      if (we_out_i) out_q <= wdata_i;
      if (we_ovr_i) ovr_q <= wdata_i;
    end
  end

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pin_o)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_o[i]    = ovr_q[i] ? per_dout_i[i] : out_q[i];
    assign pad_oe_o[i] = ovr_q[i] ? per_doe_i[i]  : dir_q[i];
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
  assign ovr_o = ovr_q;

  // R3
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_dir_i |=> dir_q == $past(wdata_i));
  // R3
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_dir_i |=> $stable(dir_q));
  // R4
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ovr_i |=> $stable(ovr_q));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q, pend_q, set;

  assign set = lvl_i & ~prev_q & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= set | (pend_q & ~clr_i);  // new edge beats clear
    end
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R7
    pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[i]) |-> $past(en_i[i] && lvl_i[i] && !prev_q[i]));
    // R8
    no_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[i] && !pend_q[i]) |=> !pend_q[i]);
    // R9
    pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
    // R10
    clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set[i]) |=> !pend_q[i]);
    // R11
    edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set[i] |=> pend_q[i]);
  end
endmodule

// File: rtl/gpio_altmux.sv
module gpio_altmux
  import gpio_altmux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [PORT_W-1:0] pad_a_i,
  output logic [PORT_W-1:0] pad_a_o,
  output logic [PORT_W-1:0] pad_a_oe_o,
  input  logic [PORT_W-1:0] pad_b_i,
  output logic [PORT_W-1:0] pad_b_o,
  output logic [PORT_W-1:0] pad_b_oe_o,
  input  logic [PORT_W-1:0] per_a_dout_i,
  input  logic [PORT_W-1:0] per_a_doe_i,
  output logic [PORT_W-1:0] per_a_din_o,
  input  logic [PORT_W-1:0] per_b_dout_i,
  input  logic [PORT_W-1:0] per_b_doe_i,
  output logic [PORT_W-1:0] per_b_din_o,
  output logic [NIRQ-1:0]   irq_pend_o
);
  logic             hit;
  logic [OFF_W-1:0] off;
  logic [PORT_W-1:0] pin_a, pin_b, dir_a, dir_b, out_a, out_b, ovr_a, ovr_b;
  logic [NIRQ-1:0]  lvl, en, clr, pend;

  assign hit = bus_addr_i[ADDR_W-1:OFF_W] == MACRO_ID;
  assign off = bus_addr_i[OFF_W-1:0];

  function automatic logic wr_at(input logic [OFF_W-1:0] o);
    return bus_we_i && hit && (off == o);
  endfunction

  gpio_port #(.W(PORT_W)) u_port_a (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (bus_wdata_i),
    .we_dir_i  (wr_at(OFF_DIR_A)),
    .we_out_i  (wr_at(OFF_OUT_A)),
    .we_ovr_i  (wr_at(OFF_OVR_A)),
    .pad_i     (pad_a_i),
    .pad_o     (pad_a_o),
    .pad_oe_o  (pad_a_oe_o),
    .per_dout_i(per_a_dout_i),
    .per_doe_i (per_a_doe_i),
    .pin_o     (pin_a),
    .dir_o     (dir_a),
    .out_o     (out_a),
    .ovr_o     (ovr_a)
  );

  gpio_port #(.W(PORT_W)) u_port_b (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (bus_wdata_i),
    .we_dir_i  (wr_at(OFF_DIR_B)),
    .we_out_i  (wr_at(OFF_OUT_B)),
    .we_ovr_i  (wr_at(OFF_OVR_B)),
    .pad_i     (pad_b_i),
    .pad_o     (pad_b_o),
    .pad_oe_o  (pad_b_oe_o),
    .per_dout_i(per_b_dout_i),
    .per_doe_i (per_b_doe_i),
    .pin_o     (pin_b),
    .dir_o     (dir_b),
    .out_o     (out_b),
    .ovr_o     (ovr_b)
  );

  assign per_a_din_o = pin_a;
  assign per_b_din_o = pin_b;

  assign lvl = {pin_a[IRQ2_BIT], pin_b[IRQ1_BIT], pin_a[IRQ0_BIT]};
  assign en  = {ovr_a[IRQ2_BIT], ovr_b[IRQ1_BIT], ovr_a[IRQ0_BIT]};
  assign clr = wr_at(OFF_IRQ) ? bus_wdata_i[NIRQ-1:0] : '0;

  gpio_irq #(.N(NIRQ)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .en_i  (en),
    .clr_i (clr),
    .pend_o(pend)
  );

  assign irq_pend_o = pend;

  always_comb begin
    bus_rdata_o = '0;
    if (hit) begin
      case (off)
        OFF_DIR_A: bus_rdata_o = dir_a;
        OFF_DIR_B: bus_rdata_o = dir_b;
        OFF_OUT_A: bus_rdata_o = out_a;
        OFF_OUT_B: bus_rdata_o = out_b;
        OFF_OVR_A: bus_rdata_o = ovr_a;
        OFF_IN_A:  bus_rdata_o = pin_a;
        OFF_IN_B:  bus_rdata_o = pin_b;
        OFF_IRQ:   bus_rdata_o = {{(DATA_W-NIRQ){1'b0}}, pend};
        OFF_OVR_B: bus_rdata_o = ovr_b;
        default:   bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: tb/sim_gpio_altmux.sv
module sim_gpio_altmux;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic       we = 0;
  logic [7:0] pa = 0, pb = 0, pa_o, pa_oe, pb_o, pb_oe;
  logic [7:0] pad_dout = 0, pad_doe = 0, pbd_dout = 0, pbd_doe = 0, pa_din, pb_din;
  logic [2:0] pend;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_altmux u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_rdata_o(rdata),
    .pad_a_i(pa), .pad_a_o(pa_o), .pad_a_oe_o(pa_oe),
    .pad_b_i(pb), .pad_b_o(pb_o), .pad_b_oe_o(pb_oe),
    .per_a_dout_i(pad_dout), .per_a_doe_i(pad_doe), .per_a_din_o(pa_din),
    .per_b_dout_i(pbd_dout), .per_b_doe_i(pbd_doe), .per_b_din_o(pb_din),
    .irq_pend_o(pend)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1;
    @(posedge clk);
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "pad_a_oe", pa_oe, 8'h00);
    chk("R1", "pad_b_oe", pb_oe, 8'h00);
    chk("R1", "pend", {5'b0, pend}, 8'h00);
    for (int o = 0; o <= 8; o++) begin
      rd(o[7:0], d);
      chk("R1", "reg read", d, 8'h00);
    end
  endtask

  task automatic t_dir_out();
    logic [7:0] d;
    wr(8'h00, 8'hC3); wr(8'h02, 8'h5A); wr(8'h01, 8'h3C); wr(8'h03, 8'h96);
    rd(8'h00, d); chk("R3", "dir_a readback", d, 8'hC3);
    rd(8'h03, d); chk("R3", "out_b readback", d, 8'h96);
    chk("R3", "pad_a_oe", pa_oe, 8'hC3);
    chk("R3", "pad_a_o", pa_o, 8'h5A);
    chk("R3", "pad_b_oe", pb_oe, 8'h3C);
    chk("R3", "pad_b_o", pb_o, 8'h96);
  endtask

  task automatic t_override();
    logic [7:0] d;
    wr(8'h00, 8'hFF); wr(8'h02, 8'h0F);
    pad_dout = 8'hAA; pad_doe = 8'h33;
    wr(8'h04, 8'hF0);
    rd(8'h04, d); chk("R4", "ovr_a readback", d, 8'hF0);
    chk("R4", "pad_a_o mixed", pa_o, (8'hAA & 8'hF0) | (8'h0F & 8'h0F));
    chk("R4", "pad_a_oe mixed", pa_oe, (8'h33 & 8'hF0) | (8'hFF & 8'h0F));
    pbd_dout = 8'h81; pbd_doe = 8'h7E;
    wr(8'h08, 8'hFF);
    chk("R4", "pad_b_o full", pb_o, 8'h81);
    chk("R4", "pad_b_oe full", pb_oe, 8'h7E);
    wr(8'h04, 8'h00); wr(8'h08, 8'h00);
    chk("R4", "pad_a_o released", pa_o, 8'h0F);
  endtask

  task automatic t_inputs();
    logic [7:0] d;
    pa = 8'hA5; pb = 8'h3E;
    @(negedge clk);
    rd(8'h05, d); chk("R5", "in_a after 1 edge", d, 8'h00);
    @(negedge clk);
    rd(8'h05, d); chk("R5", "in_a after 2 edges", d, 8'hA5);
    rd(8'h06, d); chk("R5", "in_b after 2 edges", d, 8'h3E);
    chk("R6", "per_a_din", pa_din, 8'hA5);
    chk("R6", "per_b_din", pb_din, 8'h3E);
    wr(8'h05, 8'h00); wr(8'h06, 8'hFF);
    rd(8'h05, d); chk("R5", "in_a write ignored", d, 8'hA5);
    rd(8'h06, d); chk("R5", "in_b write ignored", d, 8'h3E);
    pa = 0; pb = 0;
    settle(3);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    wr(8'h00, 8'h11);
    wr(8'h40, 8'h55); wr(8'h80, 8'h66); wr(8'hC0, 8'h77);
    rd(8'h00, d); chk("R2", "dir_a unaffected by other macros", d, 8'h11);
    rd(8'h40, d); chk("R2", "macro1 read", d, 8'h00);
    rd(8'hC2, d); chk("R2", "macro3 read", d, 8'h00);
    wr(8'h09, 8'hFF);
    rd(8'h09, d); chk("R2", "unmapped read", d, 8'h00);
    rd(8'h3F, d); chk("R2", "top offset read", d, 8'h00);
    chk("R2", "pad_a_oe", pa_oe, 8'h11);
  endtask

  task automatic t_irq_basic();
    logic [7:0] d;
    wr(8'h04, 8'h81); wr(8'h08, 8'h01);
    pa = 8'h01;
    settle(2);
    chk("R7", "A0 not yet pending", {5'b0, pend}, 8'h00);
    settle(1);
    chk("R7", "A0 pending bit0", {5'b0, pend}, 8'h01);
    pb = 8'h01;
    settle(3);
    chk("R7", "B0 pending bit1", {5'b0, pend}, 8'h03);
    pa = 8'h81;
    settle(3);
    rd(8'h07, d); chk("R10", "irq read all", d, 8'h07);
    wr(8'h07, 8'h02);
    rd(8'h07, d); chk("R10", "clear only bit1", d, 8'h05);
    settle(4);
    chk("R8", "held-high B0 no retrigger", {5'b0, pend}, 8'h05);
    wr(8'h07, 8'hFF);
    chk("R10", "clear all", {5'b0, pend}, 8'h00);
    pa = 0; pb = 0;
    settle(4);
  endtask

  task automatic t_irq_gate();
    logic [7:0] d;
    wr(8'h04, 8'h00); wr(8'h08, 8'h00);
    pa = 8'h81; pb = 8'h01;
    settle(4);
    chk("R8", "no latch with override off", {5'b0, pend}, 8'h00);
    pa = 0; pb = 0;
    settle(4);
    wr(8'h04, 8'h80);
    pa = 8'h80;
    settle(3);
    chk("R7", "A7 pending bit2", {5'b0, pend}, 8'h04);
    wr(8'h04, 8'h00);
    settle(2);
    rd(8'h07, d); chk("R9", "pending kept after override off", d, 8'h04);
    wr(8'h07, 8'h04);
    pa = 0;
    settle(4);
  endtask

  task automatic t_race();
    wr(8'h04, 8'h01);
    pa = 8'h01; settle(3);
    pa = 8'h00; settle(4);
    chk("R11", "A0 pending before race", {5'b0, pend}, 8'h01);
    pa = 8'h01;
    settle(2);
    wr(8'h07, 8'h01);
    chk("R11", "edge beats clear", {5'b0, pend}, 8'h01);
    wr(8'h07, 8'h01);
    chk("R10", "plain clear after race", {5'b0, pend}, 8'h00);
    pa = 0;
    settle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1;
    settle(1);
    t_reset();
    t_dir_out();
    t_override();
    t_inputs();
    t_decode();
    t_irq_basic();
    t_irq_gate();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule